// File: doc/BRIEF.md
# Serial DAC Code Loader

This block forms the digital front end of a current-steering converter. A host writes a conversion code over a three-wire serial port made of an active-low select, a serial clock and a data line. The block samples all three lines in a faster system clock domain, passes each through a two-flop synchronizer and finds serial clock and select edges by comparing successive synchronized samples. The system clock must therefore run at least four times faster than the serial clock.

While select is low, every rising serial clock edge shifts one data bit into a shift register, most significant bit first. The register holds only the most recent bits, so a host that pads a word out to whole bytes loses nothing: the leading bits fall off the top. A word does not load when a bit count is reached. It loads when select rises, and the converter code then moves into a hold register that drives the ladder. A one-cycle update strobe marks each load. A parameter chooses 16-bit or 14-bit resolution.

Top module: `sdac_loader`

## Requirements
- R1: After reset, `dac_o` is zero and `upd_o` is low. The shift register is also clear, so a select pulse with no clocks loads zero.
- R2: On each rising serial clock edge seen while select is low, the shift register moves toward the MSB and takes `sdi_i` into bit 0. A word sent MSB first therefore arrives with its MSB in the top bit.
- R3: Only the last RES_BITS bits clocked in are kept. Any bits clocked in before them are dropped.
- R4: A rising edge on `cs_ni` copies the shift register into `dac_o`. The new code and the `upd_o` strobe both appear on the third rising system clock edge after the rising edge of `cs_ni`.
- R5: Serial clock edges that arrive while select is high change neither the shift register nor `dac_o`.
- R6: `dac_o` keeps its value in every cycle except the one in which `upd_o` is high. `upd_o` stays high for exactly one system cycle.
- R7: With RES_BITS=14, `dac_o` is 14 bits wide and takes the last 14 bits entered, even when 16 or more bits were shifted in.
- R8: When a serial clock rise and a select rise are detected in the same system cycle, that bit is still shifted in. The loaded code is the shift register contents from before that shift.
- R9: Full scale is code 0xFFFF with RES_BITS=16 and 0x3FFF with RES_BITS=14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Serial select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, rising edge samples data, asynchronous |
| sdi_i | input | 1 | Serial data, MSB first, asynchronous |
| dac_o | output | RES_BITS | Code held for the converter |
| upd_o | output | 1 | One-cycle strobe when `dac_o` loads |

## Verification
Every input passes through two synchronizer flops and one edge flop. A level driven on a falling system clock edge therefore takes effect on the third rising edge after it: the shift register moves then for a clock rise, and `dac_o` and `upd_o` change then for a select rise. The bench drives all inputs on falling edges. After raising select it checks on the second falling edge that nothing has changed yet. On the third falling edge it expects the new code with the strobe high, and on the fourth it expects the strobe low again. Serial clock phases last two system cycles each, which keeps the 4x ratio, so each bit has settled in the shift register before the next phase or the select rise.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int unsigned PIN_CS  = 0;
  localparam int unsigned PIN_CLK = 1;
  localparam int unsigned PIN_SDI = 2;
  localparam int unsigned PIN_N   = 3;
  // select idles high, others low
  localparam logic [PIN_N-1:0] PIN_IDLE = 3'b001;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[s] <= RST_VAL;
        else         stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter int unsigned WIDTH = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] prev_o,
  output logic [WIDTH-1:0] rise_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_o <= RST_VAL;
    else         prev_o <= lvl_i;

  assign rise_o = lvl_i & ~prev_o;
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [WIDTH-1:0] sr_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      sr_o <= '0;
    else if (shift_i) sr_o <= {sr_o[WIDTH-2:0], bit_i};
endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] code_i,
  output logic [WIDTH-1:0] dac_o,
  output logic             upd_o
);
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      dac_o <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= load_i;
      if (load_i) dac_o <= code_i;
    end
endmodule

// File: rtl/sdac_loader.sv
module sdac_loader
  import sdac_pkg::*;
#(
  parameter int unsigned RES_BITS    = 16, // 16 or 14
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_ni,
  input  logic                sclk_i,
  input  logic                sdi_i,
  output logic [RES_BITS-1:0] dac_o,
  output logic                upd_o
);
  logic [PIN_N-1:0]    pin_raw, pin_syn, pin_prev, pin_rise;
  logic                shift_en, cs_rise, cs_prev;
  logic [RES_BITS-1:0] sr_q;

  always_comb begin
    pin_raw          = '0;
    pin_raw[PIN_CS]  = cs_ni;
    pin_raw[PIN_CLK] = sclk_i;
    pin_raw[PIN_SDI] = sdi_i;
  end

  sdac_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) i_sync (
    .clk_i, .rst_ni, .d_i(pin_raw), .q_o(pin_syn)
  );

  sdac_edge #(.WIDTH(PIN_N), .RST_VAL(PIN_IDLE)) i_edge (
    .clk_i, .rst_ni, .lvl_i(pin_syn), .prev_o(pin_prev), .rise_o(pin_rise)
  );

  assign cs_prev = pin_prev[PIN_CS];
  assign cs_rise = pin_rise[PIN_CS];
  // gate on the previous select sample so a coincident select rise still shifts
  assign shift_en = pin_rise[PIN_CLK] & ~cs_prev;

  sdac_shift #(.WIDTH(RES_BITS)) i_shift (
    .clk_i, .rst_ni, .shift_i(shift_en), .bit_i(pin_syn[PIN_SDI]), .sr_o(sr_q)
  );

  sdac_hold #(.WIDTH(RES_BITS)) i_hold (
    .clk_i, .rst_ni, .load_i(cs_rise), .code_i(sr_q), .dac_o, .upd_o
  );
endmodule

// File: rtl/sdac_loader_chk.sv
module sdac_loader_chk #(
  parameter int unsigned RES_BITS = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cs_prev,
  input logic                cs_rise,
  input logic [RES_BITS-1:0] sr_q,
  input logic [RES_BITS-1:0] dac_o,
  input logic                upd_o
);
  AST_DAC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> $stable(dac_o)); // R6
  AST_UPD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o); // R6
  AST_UPD_FOLLOWS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> upd_o); // R4
  AST_UPD_NEEDS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(cs_rise)); // R4
  AST_LOAD_PRE_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise |=> dac_o == $past(sr_q)); // R8
  AST_IDLE_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_prev |=> $stable(sr_q)); // R5
endmodule

bind sdac_loader sdac_loader_chk #(.RES_BITS(RES_BITS)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_prev(cs_prev), .cs_rise(cs_rise),
  .sr_q(sr_q), .dac_o(dac_o), .upd_o(upd_o)
);

// File: tb/test_sdac_loader.sv
module test_sdac_loader;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [15:0] dac16;
  logic [13:0] dac14;
  logic upd16, upd14;
  int checks = 0, errors = 0;
  logic [31:0] sr_m = '0;
  logic [15:0] exp16;

  always #10 clk = ~clk;

  sdac_loader #(.RES_BITS(16)) i_sdac_loader (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_o(dac16), .upd_o(upd16)
  );
  sdac_loader #(.RES_BITS(14)) i_sdac_loader_14 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .dac_o(dac14), .upd_o(upd14)
  );

  localparam int NV = 6;
  localparam logic [31:0] VEC_DATA [NV] = '{32'h0000_A5C3, 32'h00FF_EE12,
    32'h0000_005A, 32'h0000_FFFF, 32'hDEAD_BEEF, 32'h0000_0001};
  localparam int VEC_LEN [NV] = '{16, 24, 8, 16, 32, 1};

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); sdi = b; sclk = 1'b0;
    @(negedge clk);
    @(negedge clk); sclk = 1'b1;
    @(negedge clk);
    if (!cs_n) sr_m = {sr_m[30:0], b};
  endtask

  task automatic frame(input logic [31:0] d, input int n);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    for (int i = n - 1; i >= 0; i--) send_bit(d[i]);
    @(negedge clk); sclk = 1'b0;
  endtask

  // raise select and check timing of load (R4, R6)
  task automatic raise_cs(input string tag);
    logic [15:0] old16;
    old16 = dac16;
    @(negedge clk); cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check({tag, " R4 early upd"}, {31'd0, upd16}, 32'd0);
    check({tag, " R6 early hold"}, {16'd0, dac16}, {16'd0, old16});
    @(negedge clk);
    check({tag, " R4 upd16"}, {31'd0, upd16}, 32'd1);
    check({tag, " R4 upd14"}, {31'd0, upd14}, 32'd1);
    check({tag, " R2 R3 dac16"}, {16'd0, dac16}, {16'd0, sr_m[15:0]});
    check({tag, " R7 dac14"}, {18'd0, dac14}, {18'd0, sr_m[13:0]});
    @(negedge clk);
    check({tag, " R6 upd pulse end"}, {30'd0, upd16, upd14}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset dac16", {16'd0, dac16}, 32'd0);
    check("R1 reset dac14", {18'd0, dac14}, 32'd0);
    check("R1 reset upd", {30'd0, upd16, upd14}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 no spurious upd", {30'd0, upd16, upd14}, 32'd0);
    // empty select pulse loads cleared shift register
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    raise_cs("R1 empty");

    for (int v = 0; v < NV; v++) begin
      frame(VEC_DATA[v], VEC_LEN[v]);
      raise_cs($sformatf("vec%0d", v));
      if (v == 3) begin
        check("R9 full scale 16", {16'd0, dac16}, 32'h0000_FFFF);
        check("R9 full scale 14", {18'd0, dac14}, 32'h0000_3FFF);
      end
    end

    // R5: clocks while select high are ignored
    exp16 = dac16;
    for (int i = 0; i < 5; i++) begin
      send_bit(i[0]);
      check("R5 dac stable", {16'd0, dac16}, {16'd0, exp16});
      check("R5 no upd", {31'd0, upd16}, 32'd0);
    end
    @(negedge clk); cs_n = 1'b0;
    repeat (3) @(negedge clk);
    raise_cs("R5 sr untouched");

    // R6: dac holds mid-frame
    exp16 = dac16;
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      send_bit(1'b1);
      check("R6 mid-frame hold", {16'd0, dac16}, {16'd0, exp16});
    end
    @(negedge clk); sclk = 1'b0;
    raise_cs("R6 frame end");

    // R8: coincident clock and select rise
    frame(32'h0000_1234, 16);
    @(negedge clk); sdi = 1'b1;
    @(negedge clk); sclk = 1'b1; cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 pre-shift load", {16'd0, dac16}, 32'h0000_1234);
    check("R8 pre-shift load 14", {18'd0, dac14}, 32'h0000_1234 & 32'h3FFF);
    sr_m = {sr_m[30:0], 1'b1};
    @(negedge clk); sclk = 1'b0; cs_n = 1'b0;
    repeat (3) @(negedge clk);
    raise_cs("R8 bit kept");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule